// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends pairs of 24-bit signed audio samples over a three-wire serial link made of a bit clock, a frame clock and a data line. Each frame carries one left word and one right word. Every word is sent most significant bit first, in two's complement form. The data line changes only when the bit clock falls, so a receiver samples it on the rising edge.

The block works as clock master or as clock slave.
- As master, it divides its master clock down to a bit clock of 64 cycles per frame and a frame clock of one cycle per frame. A 2-bit code sets the ratio of master clock to frame rate: 256, 384 or 512.
- As slave, it follows a bit clock and frame clock supplied from outside. These are resampled in the master-clock domain, and the external bit clock may run at 64 or 48 cycles per frame.

Two frame formats are supported, each with its own frame-clock polarity. In the justified format the word starts on the first bit of its half-frame. In the I2S-style format the word starts one bit later. The format in effect is the OR of a pin and a register bit.

Samples are presented on a parallel input with a one-cycle strobe. They are taken into the frame only at a frame start, so a frame never mixes two sample pairs. Holding reset low acts as power-down and holds all serial outputs low.

Top module: `audio_sport_tx`

## Requirements
- R1: In master mode one bit-clock period is 4, 8 or 6 master-clock cycles for ratio codes 00, 01 and 10 (256, 512 and 384 master clocks per frame). Code 11 behaves like 00.
- R2: In master mode the frame clock has 64 bit-clock periods per frame and holds each level for 32 of them.
- R3: In the justified format (effective select 0), left is the frame-clock high half. The word's MSB is in the first bit slot of the half, followed by the remaining 23 bits, MSB first.
- R4: The data output changes only at a bit-clock falling edge. In master mode this happens on the same master-clock edge on which the bit clock falls.
- R5: In the I2S-style format (effective select 1), left is the frame-clock low half. The MSB is in the second bit slot of the half.
- R6: Bit slots of a half-frame that do not carry one of the 24 word bits drive 0.
- R7: The effective format select is fmtPin OR fmtReg.
- R8: In slave mode the block follows bclkIn and lrclkIn, with 32 or 24 bit slots per half-frame, and holds bclkOut and lrclkOut low.
- R9: A sample pair given with sampleStrobe is used from the next frame start on. Every transmitted frame carries the left and right words of one single pair.
- R10: While rst_n is low (power-down), sdata, bclkOut and lrclkOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset / power-down |
| masterMode | input | 1 | 1: generate serial clocks, 0: follow external clocks |
| fmtPin | input | 1 | Format select from a pin |
| fmtReg | input | 1 | Format select from a register bit |
| ratioSel | input | 2 | Master clock to frame rate ratio code (master mode) |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrclkIn | input | 1 | External frame clock (slave mode) |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| sampleStrobe | input | 1 | One-cycle strobe that takes leftIn/rightIn |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| lrclkOut | output | 1 | Generated frame clock (master mode) |
| sdata | output | 1 | Serial data, changes on bit-clock fall |

## Verification
Faults in the internal state are visible at the serial port within a short, fixed time.
- A wrong divider or bit counter shows up within one frame as a bit-clock period other than 4, 6 or 8 master clocks, or as a half-frame that is not 32 slots long.
- A wrong slot index or format decode shifts or swaps the decoded words. It can also put ones into the trailing zero slots, and that is visible in the very next half-frame.
- Broken frame-start capture shows up as a decoded left/right pair that does not belong together, while samples are being updated at irregular times.

// File: rtl/audio_sport_pkg.sv
package audio_sport_pkg;
  localparam int SAMPLE_W       = 24;
  localparam int SLOTS_PER_HALF = 32;
  localparam int SLOT_W         = $clog2(SLOTS_PER_HALF);
  localparam int RATIO_LO       = 256;
  localparam int RATIO_MID      = 384;
  localparam int RATIO_HI       = 512;
  // master clocks per bit-clock half period
  localparam int HALF_LO  = RATIO_LO  / (4 * SLOTS_PER_HALF);
  localparam int HALF_MID = RATIO_MID / (4 * SLOTS_PER_HALF);
  localparam int HALF_HI  = RATIO_HI  / (4 * SLOTS_PER_HALF);
  localparam int DIV_W    = $clog2(2 * HALF_HI);

  typedef struct packed {
    logic              tick;        // a new bit slot starts at the next edge
    logic              frameStart;  // that slot is the first of a frame
    logic              isLeft;      // that slot belongs to the left half
    logic [SLOT_W-1:0] slot;        // slot index within the half-frame
  } slotStrobe_t;
endpackage

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import audio_sport_pkg::*;
(
  input  logic        mclk,
  input  logic        rst_n,
  input  logic        masterMode,
  input  logic        fmtI2s,
  input  logic [1:0]  ratioSel,
  input  logic        bclkIn,
  input  logic        lrclkIn,
  output slotStrobe_t strb,
  output logic        bclkOut,
  output logic        lrclkOut
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(SLOTS_PER_HALF - 1);

  logic [DIV_W-1:0]  divCnt, divNext, halfLen, divLast;
  logic              divWrap, mTick;
  logic [SLOT_W:0]   bitCnt, bitNext;
  logic [3:0]        bSync;
  logic [1:0]        lSync;
  logic              sFall, sTick, lrNow, newHalf, sLastLr;
  logic [SLOT_W-1:0] sSlot, sSlotNext;
  logic              bclkQ, lrQ;

  // master divider
  always_comb begin
    case (ratioSel)
      2'b01:   halfLen = DIV_W'(HALF_HI);
      2'b10:   halfLen = DIV_W'(HALF_MID);
      default: halfLen = DIV_W'(HALF_LO);
    endcase
    divLast = DIV_W'(int'(halfLen) * 2 - 1);
    divWrap = divCnt >= divLast;
    divNext = divWrap ? '0 : divCnt + 1'b1;
    mTick   = masterMode && divWrap;
    bitNext = bitCnt + 1'b1;
  end

  // slave edge detection: bit clock lags frame clock by one stage
  always_comb begin
    sFall     = bSync[3] & ~bSync[2];
    sTick     = sFall & ~masterMode;
    lrNow     = lSync[1];
    newHalf   = lrNow != sLastLr;
    sSlotNext = newHalf ? '0 : ((sSlot == SLOT_MAX) ? sSlot : sSlot + 1'b1);
  end

  always_comb begin
    if (masterMode) begin
      strb.tick       = mTick;
      strb.slot       = bitNext[SLOT_W-1:0];
      strb.isLeft     = ~bitNext[SLOT_W];
      strb.frameStart = bitNext == '0;
    end else begin
      strb.tick       = sTick;
      strb.slot       = sSlotNext;
      strb.isLeft     = lrNow ^ fmtI2s;
      strb.frameStart = newHalf && (lrNow ^ fmtI2s);
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt  <= '0;
      bitCnt  <= '0;
      bclkQ   <= 1'b0;
      lrQ     <= 1'b0;
      bSync   <= '0;
      lSync   <= '0;
      sSlot   <= '0;
      sLastLr <= 1'b0;
    end else begin
      divCnt <= masterMode ? divNext : '0;
      if (mTick) bitCnt <= bitNext;
      bclkQ  <= masterMode && (divNext >= halfLen);
      if (!masterMode)  lrQ <= 1'b0;
      else if (mTick)   lrQ <= (~bitNext[SLOT_W]) ^ fmtI2s;
      bSync <= {bSync[2:0], bclkIn};
      lSync <= {lSync[0], lrclkIn};
      if (sTick) begin
        sSlot   <= sSlotNext;
        sLastLr <= lrNow;
      end
    end
  end

  assign bclkOut  = bclkQ;
  assign lrclkOut = lrQ;

  // R4: generated bit clock falls only where a slot tick was issued
  assert_bclk_fall_on_tick_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    ($fell(bclkQ) && $past(masterMode)) |-> $past(strb.tick));
  // R2: generated frame clock moves only together with a slot tick
  assert_lr_moves_on_tick_R2: assert property (@(posedge mclk) disable iff (!rst_n)
    ($past(masterMode) && !$stable(lrQ)) |-> $past(strb.tick));
endmodule

// File: rtl/sport_data.sv
module sport_data
  import audio_sport_pkg::*;
(
  input  logic                mclk,
  input  logic                rst_n,
  input  slotStrobe_t         strb,
  input  logic                fmtI2s,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleStrobe,
  output logic                sdata
);
  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] pendL, pendR, actL, actR, word;
  logic [SLOT_W-1:0]   off;
  logic [IDX_W-1:0]    idx;
  logic                inWord, bitVal, sdataQ;

  always_comb begin
    if (!strb.isLeft)        word = actR;
    else if (strb.frameStart) word = pendL;
    else                     word = actL;
    off    = fmtI2s ? strb.slot - 1'b1 : strb.slot;
    inWord = int'(off) < SAMPLE_W;
    idx    = IDX_W'(SAMPLE_W - 1 - int'(off));
    bitVal = inWord ? word[idx] : 1'b0;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pendL  <= '0;
      pendR  <= '0;
      actL   <= '0;
      actR   <= '0;
      sdataQ <= 1'b0;
    end else begin
      if (sampleStrobe) begin
        pendL <= leftIn;
        pendR <= rightIn;
      end
      if (strb.tick && strb.frameStart) begin
        actL <= pendL;
        actR <= pendR;
      end
      if (strb.tick) sdataQ <= bitVal;
    end
  end

  assign sdata = sdataQ;

  // R4: data line moves only on a slot boundary
  assert_sdata_on_tick_R4: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sdataQ) |-> $past(strb.tick));
  // R6: slots past the word are zero in either format
  assert_tail_zero_R6: assert property (@(posedge mclk) disable iff (!rst_n)
    (strb.tick && int'(strb.slot) > SAMPLE_W) |=> !sdataQ);
endmodule

// File: rtl/audio_sport_tx.sv
module audio_sport_tx
  import audio_sport_pkg::*;
(
  input  logic                mclk,
  input  logic                rst_n,
  input  logic                masterMode,
  input  logic                fmtPin,
  input  logic                fmtReg,
  input  logic [1:0]          ratioSel,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                sampleStrobe,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                sdata
);
  slotStrobe_t strb;
  logic        fmtI2s;

  assign fmtI2s = fmtPin | fmtReg;

  sport_ctrl u_ctrl (
    .mclk(mclk), .rst_n(rst_n), .masterMode(masterMode), .fmtI2s(fmtI2s),
    .ratioSel(ratioSel), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .strb(strb),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut)
  );

  sport_data u_data (
    .mclk(mclk), .rst_n(rst_n), .strb(strb), .fmtI2s(fmtI2s),
    .leftIn(leftIn), .rightIn(rightIn), .sampleStrobe(sampleStrobe), .sdata(sdata)
  );

  // R8: generated clocks stay low while following external clocks
  assert_slave_quiet_R8: assert property (@(posedge mclk) disable iff (!rst_n)
    !masterMode |=> (!bclkOut && !lrclkOut));
endmodule

// File: tb/audio_sport_tx_tb.sv
module audio_sport_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic masterMode = 1'b1, fmtPin = 1'b0, fmtReg = 1'b0;
  logic [1:0] ratioSel = 2'b00;
  logic bclkIn = 1'b0, lrclkIn = 1'b0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic sampleStrobe = 1'b0;
  logic bclkOut, lrclkOut, sdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  audio_sport_tx u_dut (
    .mclk(mclk), .rst_n(rst_n), .masterMode(masterMode), .fmtPin(fmtPin),
    .fmtReg(fmtReg), .ratioSel(ratioSel), .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .leftIn(leftIn), .rightIn(rightIn), .sampleStrobe(sampleStrobe),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdata(sdata)
  );

  // ---------------- slave clock source ----------------
  bit slvRun = 0;
  int slvSlots = 32;
  int slvPhase = 0, slvSlot = 0;
  always @(negedge mclk) begin
    if (slvRun) begin
      slvPhase = (slvPhase + 1) % 16;
      if (slvPhase == 0) begin
        slvSlot = slvSlot + 1;
        if (slvSlot >= slvSlots) begin
          slvSlot = 0;
          lrclkIn = ~lrclkIn;
        end
      end
      bclkIn = slvPhase >= 8;
    end
  end

  // ---------------- serial receiver model ----------------
  bit benchI2s = 0, clrReq = 0, pairMode = 0, started = 0, haveL = 0, curLeft = 0;
  logic prevB = 0, prevLr = 0;
  logic [23:0] acc = 0, recL = 0, lastL = 0, lastR = 0, prevFrameL = 0;
  int slotN = 0, frames = 0, tailErr = 0, halfSlots = 0, period = 0, sinceRise = 0;
  int pairErr = 0, distinct = 0;

  always @(negedge mclk) begin
    logic busB, busL;
    int off;
    if (clrReq) begin
      clrReq = 0; started = 0; haveL = 0; frames = 0; tailErr = 0;
      pairErr = 0; distinct = 0; halfSlots = 0;
    end
    busB = masterMode ? bclkOut : bclkIn;
    busL = masterMode ? lrclkOut : lrclkIn;
    sinceRise++;
    if (busB && !prevB) begin
      period = sinceRise;
      sinceRise = 0;
      if (busL != prevLr) begin
        if (started) begin
          halfSlots = slotN;
          if (curLeft) begin recL = acc; haveL = 1; end
          else if (haveL) begin
            lastL = recL; lastR = acc; frames++; haveL = 0;
            if (pairMode && ((recL ^ 24'h5A5A5A) != acc)) pairErr++;
            if (recL != prevFrameL) distinct++;
            prevFrameL = recL;
          end
        end
        started = 1;
        slotN = 0;
        acc = 0;
        curLeft = busL ^ benchI2s;
      end
      off = benchI2s ? slotN - 1 : slotN;
      if (off >= 0 && off < 24) acc[23-off] = sdata;
      else if (sdata !== 1'b0 && started) tailErr++;
      slotN++;
      prevLr = busL;
    end
    prevB = busB;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(negedge mclk);
  endtask

  task automatic loadPair(input logic [23:0] l, input logic [23:0] r);
    @(negedge mclk);
    leftIn = l; rightIn = r; sampleStrobe = 1;
    @(negedge mclk);
    sampleStrobe = 0;
  endtask

  task automatic settle();
    // skip the post-change window: two frames, then restart statistics
    waitFrames(2);
    clrReq = 1;
    @(negedge mclk);
    @(negedge mclk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (5) @(negedge mclk);
    chk("R10 sdata in power-down", sdata, 0);
    chk("R10 bclkOut in power-down", bclkOut, 0);
    chk("R10 lrclkOut in power-down", lrclkOut, 0);
    rst_n = 1;
  endtask

  task automatic t_master(input logic [1:0] code, input int expPer, input bit pin,
                          input bit rg, input logic [23:0] l, input logic [23:0] r);
    masterMode = 1; ratioSel = code; fmtPin = pin; fmtReg = rg;
    benchI2s = pin | rg;
    loadPair(l, r);
    settle();
    waitFrames(3);
    chk($sformatf("R3/R5/R7 left word code=%0d fmt=%0d%0d", code, pin, rg), lastL, l);
    chk($sformatf("R3/R5/R7 right word code=%0d fmt=%0d%0d", code, pin, rg), lastR, r);
    chk("R6 trailing slots zero", tailErr, 0);
    chk($sformatf("R1 bit clock period code=%0d", code), period, expPer);
    chk("R2 slots per half-frame", halfSlots, 32);
  endtask

  task automatic t_slave(input int slots, input bit i2s, input logic [23:0] l,
                         input logic [23:0] r);
    slvRun = 0;
    @(negedge mclk);
    masterMode = 0; fmtPin = i2s; fmtReg = 0; benchI2s = i2s;
    slvSlots = slots; slvPhase = 0; slvSlot = 0;
    slvRun = 1;
    loadPair(l, r);
    settle();
    waitFrames(3);
    chk($sformatf("R8 slave left slots=%0d", slots), lastL, l);
    chk($sformatf("R8 slave right slots=%0d", slots), lastR, r);
    chk("R8 slave half length", halfSlots, slots);
    chk("R6 slave trailing zero", tailErr, 0);
    chk("R8 bclkOut held low", bclkOut, 0);
    chk("R8 lrclkOut held low", lrclkOut, 0);
    slvRun = 0;
  endtask

  task automatic t_atomic();
    logic [23:0] l;
    slvRun = 0;
    masterMode = 1; ratioSel = 2'b00; fmtPin = 0; fmtReg = 0; benchI2s = 0;
    loadPair(24'h000001, 24'h000001 ^ 24'h5A5A5A);
    settle();
    pairMode = 1;
    for (int k = 0; k < 40; k++) begin
      l = 24'(k * 24'h13579B + 24'h800001);
      loadPair(l, l ^ 24'h5A5A5A);
      repeat (100 + (k * 37) % 211) @(negedge mclk);
    end
    waitFrames(2);
    pairMode = 0;
    chk("R9 no mixed sample pairs", pairErr, 0);
    checks++;
    if (distinct < 10) begin
      failures++;
      $display("FAIL R9 sample updates seen actual=%0d expected>=10", distinct);
    end
    chk("R9 last pair taken", lastL, l);
  endtask

  initial begin
    t_reset();
    t_master(2'b00, 4, 0, 0, 24'h812345, 24'h00F0A5);   // R1 256fs, R3 justified
    t_master(2'b01, 8, 0, 0, 24'h7FFFFF, 24'h800000);   // R1 512fs
    t_master(2'b10, 6, 0, 1, 24'hC3A501, 24'h1E2D3C);   // R1 384fs, R7 reg bit -> R5
    t_master(2'b11, 4, 1, 0, 24'h00FF00, 24'hA5A5A5);   // R1 unused code, R7 pin -> R5
    t_master(2'b00, 4, 1, 1, 24'h400001, 24'hFFFFFE);   // R7 both set
    t_slave(32, 0, 24'h89ABCD, 24'h123456);              // R8 64fs justified
    t_slave(24, 0, 24'hF00F0F, 24'h0A0B0C);              // R8 48fs justified
    t_slave(32, 1, 24'h5C3B2A, 24'hE1D2C3);              // R8 64fs I2S-style
    t_atomic();                                          // R9
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule